// File: doc/BRIEF.md
# Multi-Cycle Instruction Execution Sequencer

This block is the control unit of a small multi-cycle processor. It walks each instruction through a chain of phases: it reads the instruction word from memory, samples the decoded instruction fields, reads an input operand from memory when the instruction needs one, runs the ALU for one cycle, and writes the result back to memory when the destination lives there. An instruction therefore takes three, four or five phases. The memory phases wait on a ready handshake, so their length is set by the memory.

The sequencer drives one synchronous memory request port. This port carries an address, a read strobe and a write strobe, and it accepts a ready input and read data. The fetched instruction word goes out to an external decoder. That decoder returns the ALU operation, a flag saying the input operand is in memory, a flag saying the output operand is in memory, and the memory operand address. The sequencer keeps the program counter and drives the ALU controls: the operation, the operand read from memory, an execute strobe and a flag-update strobe. It raises a one-cycle done pulse when each instruction completes.

Phases and their encoding on `phase`: FETCH (0), DECODE (1), OPFETCH (2), EXEC (3), STORE (4). The transitions are:
- FETCH→DECODE when ready is seen.
- DECODE→OPFETCH when the input operand is in memory, otherwise DECODE→EXEC.
- OPFETCH→EXEC when ready is seen.
- EXEC→STORE when the output operand is in memory, otherwise EXEC→FETCH.
- STORE→FETCH when ready is seen.

Top module: `instr_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in FETCH (`phase`=0) with `pc`=0. `mem_rd` is high with `mem_addr`=0 and `done` is low. A reset given in the middle of an instruction abandons it.
- R2: In FETCH, `mem_rd` is high and `mem_addr` equals `pc`. Both are held until `mem_ready` is seen at a clock edge. At that edge `mem_rdata` is captured onto `instr_word`, `pc` increases by one, and the phase moves to DECODE.
- R3: DECODE lasts exactly one cycle and raises no memory strobe. At its edge it captures `dec_op`, `dec_src_mem`, `dec_dst_mem` and `dec_addr`. `alu_op` then shows the captured operation until the next DECODE.
- R4: OPFETCH is entered only when the captured `dec_src_mem` is 1. It drives `mem_rd` with `mem_addr` equal to the captured address and holds it until ready. At the ready edge `mem_rdata` is captured onto `opnd_data`.
- R5: EXEC lasts exactly one cycle. `alu_go` and `flags_we` are high in that cycle and in no other cycle.
- R6: STORE is entered only when the captured `dec_dst_mem` is 1. It drives `mem_wr` with `mem_addr` equal to the captured address and holds it until ready.
- R7: `done` is high for exactly one cycle, the last cycle of each instruction. An instruction with w wait cycles per memory phase takes (1+w) + 1 + src·(1+w) + 1 + dst·(1+w) cycles.
- R8: Changes to the decoded inputs outside the DECODE cycle have no effect on the phase sequence, `alu_op` or the operand address.
- R9: `mem_rd` and `mem_wr` are never high together, and neither is high in DECODE or EXEC.
- R10: The phases always run in the order FETCH, DECODE, optional OPFETCH, EXEC, optional STORE, and then back to FETCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_ready | input | 1 | Memory has completed the current request |
| mem_rdata | input | DW | Read data from memory |
| mem_addr | output | AW | Request address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| instr_word | output | DW | Fetched instruction word, sent to the decoder |
| dec_op | input | OPW | Decoded ALU operation |
| dec_src_mem | input | 1 | Input operand is in memory |
| dec_dst_mem | input | 1 | Output operand is in memory |
| dec_addr | input | AW | Memory operand address |
| alu_op | output | OPW | ALU operation held for execute |
| opnd_data | output | DW | Operand read in OPFETCH |
| alu_go | output | 1 | ALU executes this cycle |
| flags_we | output | 1 | Status flags update this cycle |
| pc | output | AW | Program counter |
| phase | output | 3 | Current phase code |
| done | output | 1 | Last cycle of an instruction |

## Verification
Every registered result (`pc`, `instr_word`, `alu_op`, `opnd_data` and `phase`) changes at the edge that closes a phase, so it is due one cycle after the ready or decode cycle that caused it. The strobes and `done` are decoded from the current phase and `mem_ready` within the same cycle. The bench drives ready and the decoded fields at the falling edge and samples one time unit after it, so every value is read in a settled half-cycle. Each instruction is timed from the first FETCH cycle to the cycle where `done` is seen. That count is compared with the cycle formula, computed from the wait setting and the two memory flags.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        PH_FETCH   = 3'd0,
        PH_DECODE  = 3'd1,
        PH_OPFETCH = 3'd2,
        PH_EXEC    = 3'd3,
        PH_STORE   = 3'd4
    } phase_t;

    localparam int OP_W = 2;

    localparam logic [OP_W-1:0] OP_MOV = 2'd0;
    localparam logic [OP_W-1:0] OP_ADD = 2'd1;
    localparam logic [OP_W-1:0] OP_AND = 2'd2;
    localparam logic [OP_W-1:0] OP_OR  = 2'd3;

endpackage

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mem_ready,
    input  logic   src_mem_now,
    input  logic   dst_mem_q,
    output phase_t phase,
    output logic   fetch_fin,
    output logic   decode_fin,
    output logic   opnd_fin,
    output logic   store_fin
);

    phase_t phase_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
        end else begin
            phase <= phase_nxt;
        end
    end

    // transitions
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_FETCH:   if (mem_ready) phase_nxt = PH_DECODE;
            PH_DECODE:  phase_nxt = src_mem_now ? PH_OPFETCH : PH_EXEC;
            PH_OPFETCH: if (mem_ready) phase_nxt = PH_EXEC;
            PH_EXEC:    phase_nxt = dst_mem_q ? PH_STORE : PH_FETCH;
            PH_STORE:   if (mem_ready) phase_nxt = PH_FETCH;
            default:    phase_nxt = PH_FETCH;
        endcase
    end

    // phase-completion strobes
    always_comb begin
        fetch_fin  = 1'b0;
        decode_fin = 1'b0;
        opnd_fin   = 1'b0;
        store_fin  = 1'b0;
        unique case (phase)
            PH_FETCH:   fetch_fin  = mem_ready;
            PH_DECODE:  decode_fin = 1'b1;
            PH_OPFETCH: opnd_fin   = mem_ready;
            PH_EXEC:    ;
            PH_STORE:   store_fin  = mem_ready;
            default:    ;
        endcase
    end

endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
    parameter int AW   = 8,
    parameter int STEP = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (inc) begin
            pc <= pc + STEP_V;
        end
    end

endmodule

// File: rtl/seq_dec_latch.sv
module seq_dec_latch #(
    parameter int OPW = 2,
    parameter int AW  = 8,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fetch_fin,
    input  logic           decode_fin,
    input  logic           opnd_fin,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [OPW-1:0] dec_op,
    input  logic           dec_src_mem,
    input  logic           dec_dst_mem,
    input  logic [AW-1:0]  dec_addr,
    output logic [DW-1:0]  instr_q,
    output logic [OPW-1:0] op_q,
    output logic           src_mem_q,
    output logic           dst_mem_q,
    output logic [AW-1:0]  addr_q,
    output logic [DW-1:0]  opnd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
        end else if (fetch_fin) begin
            instr_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= '0;
            src_mem_q <= 1'b0;
            dst_mem_q <= 1'b0;
            addr_q    <= '0;
        end else if (decode_fin) begin
            op_q      <= dec_op;
            src_mem_q <= dec_src_mem;
            dst_mem_q <= dec_dst_mem;
            addr_q    <= dec_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
        end else if (opnd_fin) begin
            opnd_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
    import seq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int OPW     = 2,
    parameter int PC_STEP = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [DW-1:0]  instr_word,
    input  logic [OPW-1:0] dec_op,
    input  logic           dec_src_mem,
    input  logic           dec_dst_mem,
    input  logic [AW-1:0]  dec_addr,
    output logic [OPW-1:0] alu_op,
    output logic [DW-1:0]  opnd_data,
    output logic           alu_go,
    output logic           flags_we,
    output logic [AW-1:0]  pc,
    output logic [2:0]     phase,
    output logic           done
);

    phase_t         cur;
    logic           fetch_fin;
    logic           decode_fin;
    logic           opnd_fin;
    logic           store_fin;
    logic           src_mem_q;
    logic           dst_mem_q;
    logic [AW-1:0]  addr_q;

    seq_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mem_ready   (mem_ready),
        .src_mem_now (dec_src_mem),
        .dst_mem_q   (dst_mem_q),
        .phase       (cur),
        .fetch_fin   (fetch_fin),
        .decode_fin  (decode_fin),
        .opnd_fin    (opnd_fin),
        .store_fin   (store_fin)
    );

    seq_pc #(.AW(AW), .STEP(PC_STEP)) u_pc (
        .clk (clk),
        .rst (rst),
        .inc (fetch_fin),
        .pc  (pc)
    );

    seq_dec_latch #(.OPW(OPW), .AW(AW), .DW(DW)) u_lat (
        .clk         (clk),
        .rst         (rst),
        .fetch_fin   (fetch_fin),
        .decode_fin  (decode_fin),
        .opnd_fin    (opnd_fin),
        .mem_rdata   (mem_rdata),
        .dec_op      (dec_op),
        .dec_src_mem (dec_src_mem),
        .dec_dst_mem (dec_dst_mem),
        .dec_addr    (dec_addr),
        .instr_q     (instr_word),
        .op_q        (alu_op),
        .src_mem_q   (src_mem_q),
        .dst_mem_q   (dst_mem_q),
        .addr_q      (addr_q),
        .opnd_q      (opnd_data)
    );

    // output decode from the current phase
    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mem_addr = addr_q;
        alu_go   = 1'b0;
        flags_we = 1'b0;
        done     = 1'b0;
        unique case (cur)
            PH_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = pc;
            end
            PH_DECODE: ;
            PH_OPFETCH: mem_rd = 1'b1;
            PH_EXEC: begin
                alu_go   = 1'b1;
                flags_we = 1'b1;
                done     = ~dst_mem_q;
            end
            PH_STORE: begin
                mem_wr = 1'b1;
                done   = store_fin;
            end
            default: ;
        endcase
    end

    assign phase = cur;

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_ready,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          flags_we,
    input logic [AW-1:0] pc,
    input logic [2:0]    phase,
    input logic          done
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (phase == 3'd0 && pc == '0 && !done));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && mem_ready) |=> (pc == $past(pc) + 1'b1 && phase == 3'd1));

    p_hold_request_r6: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_ready) |=>
            (mem_rd == $past(mem_rd) && mem_wr == $past(mem_wr) && $stable(mem_addr)));

    p_flags_exec_r5: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> (phase == 3'd3));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (phase == 3'd0 && !done));

    p_decode_next_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1) |=> (phase == 3'd2 || phase == 3'd3));

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && !((phase == 3'd1 || phase == 3'd3) && (mem_rd || mem_wr)));

endmodule

bind instr_sequencer seq_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_ready (mem_ready),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .flags_we  (flags_we),
    .pc        (pc),
    .phase     (phase),
    .done      (done)
);

// File: tb/instr_sequencer_tb.sv
module instr_sequencer_tb;

    localparam int CLK_PER = 10;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int OPW = 2;
    localparam logic [DW-1:0] KEY = 16'h5A5A;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mem_ready = 1'b0;
    logic [DW-1:0]  mem_rdata;
    logic [AW-1:0]  mem_addr;
    logic           mem_rd, mem_wr;
    logic [DW-1:0]  instr_word;
    logic [OPW-1:0] dec_op = '0;
    logic           dec_src_mem = 1'b0;
    logic           dec_dst_mem = 1'b0;
    logic [AW-1:0]  dec_addr = '0;
    logic [OPW-1:0] alu_op;
    logic [DW-1:0]  opnd_data;
    logic           alu_go, flags_we, done;
    logic [AW-1:0]  pc;
    logic [2:0]     phase;

    int total = 0;
    int bad   = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    bit finished = 0;

    always #(CLK_PER/2) clk = ~clk;

    instr_sequencer #(.AW(AW), .DW(DW), .OPW(OPW)) u_dut (
        .clk(clk), .rst(rst), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .instr_word(instr_word), .dec_op(dec_op), .dec_src_mem(dec_src_mem),
        .dec_dst_mem(dec_dst_mem), .dec_addr(dec_addr), .alu_op(alu_op),
        .opnd_data(opnd_data), .alu_go(alu_go), .flags_we(flags_we),
        .pc(pc), .phase(phase), .done(done)
    );

    // memory model: read data is the address xor a key; ready after wait_cfg cycles
    assign mem_rdata = {{(DW-AW){1'b0}}, mem_addr} ^ KEY;

    always @(negedge clk) begin
        if (mem_rd || mem_wr) begin
            if (wcnt == wait_cfg) begin
                mem_ready <= 1'b1;
                wcnt <= 0;
            end else begin
                mem_ready <= 1'b0;
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
            wcnt <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // one instruction, starting at the negedge of its first FETCH cycle
    task automatic run_instr(input logic [OPW-1:0] op, input bit src, input bit dst,
                             input int w, input logic [AW-1:0] addr);
        int cyc = 0;
        int flag_cyc = 0;
        int strobe_err = 0;
        int exec_op = -1;
        int store_addr = -1;
        int sig = 0;
        int exp_sig;
        int exp_cyc;
        logic [AW-1:0] pc0;
        logic [2:0] last_ph;
        bit changed = 0;
        wait_cfg = w;
        @(negedge clk);
        #1;
        dec_op = op;
        dec_src_mem = src;
        dec_dst_mem = dst;
        dec_addr = addr;
        pc0 = pc;
        last_ph = 3'd7;
        forever begin
            if (phase != last_ph) begin
                sig = (sig << 3) | int'(phase);
                last_ph = phase;
            end
            if (mem_rd && mem_wr) strobe_err++;
            if ((phase == 3'd1 || phase == 3'd3) && (mem_rd || mem_wr)) strobe_err++;
            if (flags_we || alu_go) flag_cyc++;
            if (phase == 3'd3) exec_op = int'(alu_op);
            if (mem_wr) store_addr = int'(mem_addr);
            cyc++;
            if (done || cyc > 100) break;
            @(negedge clk);
            #1;
            // R8: scramble the decoded inputs once decode has passed
            if (!changed && phase != 3'd0 && phase != 3'd1) begin
                dec_op = ~op;
                dec_src_mem = ~src;
                dec_dst_mem = ~dst;
                dec_addr = ~addr;
                changed = 1;
            end
        end
        exp_cyc = (1 + w) + 1 + (src ? (1 + w) : 0) + 1 + (dst ? (1 + w) : 0);
        exp_sig = (0 << 3) | 1;
        if (src) exp_sig = (exp_sig << 3) | 2;
        exp_sig = (exp_sig << 3) | 3;
        if (dst) exp_sig = (exp_sig << 3) | 4;
        check(cyc == exp_cyc, "R7 cycle count", cyc, exp_cyc);
        check(sig == exp_sig, "R10 phase order", sig, exp_sig);
        check(exec_op == int'(op), "R3/R8 alu_op in exec", exec_op, int'(op));
        check(flag_cyc == 1, "R5 execute strobes", flag_cyc, 1);
        check(strobe_err == 0, "R9 strobe rules", strobe_err, 0);
        check(pc == pc0 + 1'b1, "R2 pc increment", int'(pc), int'(pc0) + 1);
        check(instr_word == ({{(DW-AW){1'b0}}, pc0} ^ KEY), "R2 instr word",
              int'(instr_word), int'({{(DW-AW){1'b0}}, pc0} ^ KEY));
        if (src)
            check(opnd_data == ({{(DW-AW){1'b0}}, addr} ^ KEY), "R4 operand data",
                  int'(opnd_data), int'({{(DW-AW){1'b0}}, addr} ^ KEY));
        check(store_addr == (dst ? int'(addr) : -1), "R6 store address",
              store_addr, dst ? int'(addr) : -1);
    endtask

    initial begin
        #(CLK_PER * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(phase == 3'd0 && pc == '0, "R1 reset phase/pc", int'(phase), 0);
        check(mem_rd && !mem_wr && mem_addr == '0 && !done, "R1 reset strobes",
              int'({mem_rd, mem_wr, done}), 4);
        // align: leave time so run_instr's first negedge is the first FETCH cycle
        @(posedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        // sweep over opcode, memory flags and wait states (starting one negedge early)
        for (int w = 0; w < 3; w++) begin
            for (int op = 0; op < 4; op++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int d = 0; d < 2; d++) begin
                        if (w == 0 && op == 0 && s == 0 && d == 0) begin
                            // first instruction starts at this negedge; re-align with reset
                            @(posedge clk);
                            rst = 1'b1;
                            @(posedge clk);
                            #1;
                            rst = 1'b0;
                        end
                        run_instr(OPW'(op), s[0], d[0], w, AW'(8'h40 + op * 4 + s * 2 + d));
                    end
                end
            end
        end
        // R1: reset in the middle of an operand fetch
        wait_cfg = 3;
        @(negedge clk);
        #1;
        dec_src_mem = 1'b1;
        dec_dst_mem = 1'b1;
        while (phase != 3'd2) begin
            @(negedge clk);
            #1;
        end
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check(phase == 3'd0 && pc == '0, "R1 mid-instruction reset", int'(pc), 0);
        check(!done && mem_rd && mem_addr == '0, "R1 fetch restarts at zero",
              int'(mem_addr), 0);
        finish_run();
    end

endmodule